// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block is a memory-mapped general-purpose pin controller for up to 32 pins, reached through a simple word-wide register bus with combinational reads and single-cycle writes. Each pin has an output level, a direction and a trigger setting. Pins configured as inputs are resynchronised into the clock domain, and the synchronised level is watched for the configured trigger condition.

Each trigger event sets a bit in a raw event latch. The latch is masked by an enable register to form the pending view, and any pending bit raises the single interrupt output. Software acknowledges events by writing ones to a clear register. Three per-pin configuration registers select level or edge sensitivity, polarity, and the any-transition mode. Because the block offers the any-transition mode, it reports version 3.

Top module: `gpio_irq_unit`

## Requirements
- R1: Registers are 32-bit words decoded from bus_addr[5:2] with bus_addr[1:0] equal to 0: 0x00 pin value, 0x04 direction, 0x08 interrupt enable, 0x0C raw event status, 0x10 pending, 0x14 clear, 0x18 trigger kind, 0x1C polarity, 0x20 version, 0x24 any-transition. The version register is read-only and reads 3.
- R2: A direction bit of 1 makes the pin an input (pin_oe bit 0). A direction bit of 0 makes it an output (pin_oe bit 1), and pin_out carries the value register. After reset every pin is an input and the value register is 0.
- R3: A read of the value register returns the synchronised pin_in level for input pins and the stored output level for output pins.
- R4: With the trigger-kind bit at 0 the pin is level-sensitive: a polarity bit of 1 triggers on a high level, 0 on a low level.
- R5: With the trigger-kind bit at 1 and the any-transition bit at 0, a polarity bit of 1 triggers on a rising edge and 0 on a falling edge. The pin passes through a two-flop synchroniser, and an edge is found by comparing the synchronised level with its value one cycle earlier. A change of pin_in is therefore visible in the status register after three rising clock edges.
- R6: With both the trigger-kind bit and the any-transition bit at 1, every transition of the pin sets its status bit, whatever the polarity.
- R7: Writing 1 to a bit of the clear register clears that status bit. Writing 0 leaves it unchanged, and status bits never drop without a clear.
- R8: The interrupt enable register resets to 0. The pending register reads status AND enable, and irq is high exactly when some pending bit is set.
- R9: When a trigger event and a clear of the same bit land in the same cycle, the bit remains set.
- R10: Register bits at and above NPINS read as 0, and writes to them are ignored.
- R11: In level mode the status bit is set again on every cycle the active level persists, so a clear has no lasting effect while the level remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output levels to the pads |
| pin_oe | output | NPINS | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
A trigger event and a software clear can hit the same status bit in one cycle. The bench provokes this by changing a pin in any-transition mode and then timing a write of that bit to the clear register so that it commits on the third rising edge after the change, the same edge on which the synchronised edge is latched. It judges the outcome by reading the status register afterwards, where the bit must still be set. It also checks that a plain clear without a coincident event does empty the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned BUS_W = 32;
  localparam logic [BUS_W-1:0] BLOCK_VERSION = 32'd3;

  // register slot = bus_addr[5:2]; the bus decode depends on these slots
  typedef enum logic [3:0] {
    SLOT_LEVEL  = 4'd0,
    SLOT_DIR    = 4'd1,
    SLOT_ENA    = 4'd2,
    SLOT_RAW    = 4'd3,
    SLOT_PEND   = 4'd4,
    SLOT_ACK    = 4'd5,
    SLOT_KIND   = 4'd6,
    SLOT_POL    = 4'd7,
    SLOT_VER    = 4'd8,
    SLOT_ANY    = 4'd9
  } reg_slot_e;

  // trigger decision for one pin
  function automatic logic trig_hit(logic now_v, logic was_v,
                                    logic edge_mode, logic pol, logic any_tr);
    logic hit;
    if (!edge_mode)  hit = pol ? now_v : ~now_v;
    else if (any_tr) hit = now_v ^ was_v;
    else             hit = pol ? (now_v & ~was_v) : (~now_v & was_v);
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect import gpio_irq_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] any_tr,
  output logic [W-1:0] evt
);
  logic [W-1:0] lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign evt[i] = trig_hit(lvl[i], lvl_prev[i], edge_mode[i], pol[i], any_tr[i]);
  end

  // single-polarity edge triggers cannot fire on two consecutive cycles
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & $past(evt) & edge_mode & ~any_tr & $past(edge_mode & ~any_tr)) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit import gpio_irq_pkg::*; #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] out_q, dir_q, ena_q, kind_q, pol_q, any_q, raw_q;
  logic [NPINS-1:0] lvl_sync, evt, ack_mask, pending, wdat, rd_field;
  logic [3:0]       slot;
  logic             word_ok, wr_hit;

  assign word_ok = (bus_addr[1:0] == 2'b00);
  assign slot    = bus_addr[5:2];
  assign wr_hit  = bus_sel & bus_we & word_ok;
  assign wdat    = bus_wdata[NPINS-1:0];

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync));

  gpio_irq_detect #(.W(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .edge_mode(kind_q),
    .pol(pol_q), .any_tr(any_q), .evt(evt));

  assign ack_mask = (wr_hit && slot == SLOT_ACK) ? wdat : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      ena_q  <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      raw_q  <= '0;
    end else begin
      if (wr_hit) begin
        case (slot)
          SLOT_LEVEL: out_q  <= wdat;
          SLOT_DIR:   dir_q  <= wdat;
          SLOT_ENA:   ena_q  <= wdat;
          SLOT_KIND:  kind_q <= wdat;
          SLOT_POL:   pol_q  <= wdat;
          SLOT_ANY:   any_q  <= wdat;
          default: ;
        endcase
      end
      // a fresh event outranks a clear of the same bit
      raw_q <= (raw_q & ~ack_mask) | evt;
    end
  end

  assign pending = raw_q & ena_q;
  assign irq     = |pending;
  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  always_comb begin
    case (slot)
      SLOT_LEVEL: rd_field = (dir_q & lvl_sync) | (~dir_q & out_q);
      SLOT_DIR:   rd_field = dir_q;
      SLOT_ENA:   rd_field = ena_q;
      SLOT_RAW:   rd_field = raw_q;
      SLOT_PEND:  rd_field = pending;
      SLOT_KIND:  rd_field = kind_q;
      SLOT_POL:   rd_field = pol_q;
      SLOT_ANY:   rd_field = any_q;
      default:    rd_field = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (word_ok) begin
      if (slot == SLOT_VER) bus_rdata = BLOCK_VERSION;
      else                  bus_rdata[NPINS-1:0] = rd_field;
    end
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_mask & ~evt)) |=> ((raw_q & $past(ack_mask & ~evt)) == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask == '0) |=> (($past(raw_q) & ~raw_q) == '0));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw_q & $past(evt)) == $past(evt)));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic         irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_unit #(.NPINS(N), .SYNC_STAGES(2)) u_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // bench model: mode 0 level-high, 1 level-low, 2 rise, 3 fall, 4 any
  function automatic bit lvl_active(int m, bit v);
    return (m == 0) ? v : (m == 1) ? !v : 1'b0;
  endfunction
  function automatic bit edge_seen(int m, bit a, bit b);
    return (m == 2) ? (!a && b) : (m == 3) ? (a && !b) : (m == 4) ? (a != b) : 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(6'h08, d); check("R8 enable reset", d, 32'h0);
    rd(6'h20, d); check("R1 version", d, 32'd3);
    rd(6'h04, d); check("R2 direction reset", d, 32'hFF);
    rd(6'h10, d); check("R8 pending reset", d, 32'h0);
    check("R8 irq reset", {31'd0, irq}, 32'h0);
    check("R2 oe reset", {24'd0, pin_oe}, 32'h0);

    // R1 version is read-only, R10 upper bits
    wr(6'h20, 32'h55);
    rd(6'h20, d); check("R1 version read-only", d, 32'd3);
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, d); check("R10 upper bits zero", d, 32'h0000_00FF);
    wr(6'h08, 32'h0);

    // R2/R3 direction and value mux
    wr(6'h04, 32'h0F);
    wr(6'h00, 32'hA5);
    check("R2 pin_out", {24'd0, pin_out}, 32'hA5);
    check("R2 pin_oe", {24'd0, pin_oe}, 32'hF0);
    pin_in = 8'h03;
    settle();
    rd(6'h00, d); check("R3 value readback", d, 32'hA3);
    pin_in = 8'h00;
    wr(6'h04, 32'hFF);

    // sweep: every mode against every start/end level
    for (int m = 0; m < 5; m++) begin
      for (int t = 0; t < 4; t++) begin
        int p = (m * 4 + t) % N;
        bit a = t[1];
        bit b = t[0];
        bit exp_b;
        logic [7:0] bitp = 8'd1 << p;
        wr(6'h18, (m >= 2) ? {24'd0, bitp} : 32'h0);
        wr(6'h1C, (m == 1 || m == 3) ? {24'd0, ~bitp} : 32'hFF);
        wr(6'h24, (m == 4) ? {24'd0, bitp} : 32'h0);
        pin_in = a ? bitp : 8'h00;
        settle();
        wr(6'h14, 32'hFF);
        @(negedge clk);
        rd(6'h0C, d);
        // R11 level re-latch after clear
        check($sformatf("R11 mode%0d start%0d relatch", m, a), {31'd0, d[p]},
              {31'd0, lvl_active(m, a)});
        pin_in = b ? bitp : 8'h00;
        settle();
        rd(6'h0C, d);
        exp_b = (m < 2) ? (lvl_active(m, a) | lvl_active(m, b)) : edge_seen(m, a, b);
        check($sformatf("R4 R5 R6 mode%0d %0d->%0d", m, a, b), {31'd0, d[p]},
              {31'd0, exp_b});
      end
    end

    // R7/R8 directed: rising trigger on pin 2, other pins quiet
    pin_in = 8'h00;
    wr(6'h18, 32'h04); wr(6'h1C, 32'hFF); wr(6'h24, 32'h0);
    settle();
    wr(6'h14, 32'hFF);
    rd(6'h0C, d); check("R7 status empty", d, 32'h0);
    pin_in = 8'h04;
    settle();
    rd(6'h0C, d); check("R5 rise latched", d, 32'h04);
    rd(6'h10, d); check("R8 masked pending", d, 32'h0);
    check("R8 irq masked", {31'd0, irq}, 32'h0);
    wr(6'h08, 32'h04);
    rd(6'h10, d); check("R8 pending", d, 32'h04);
    check("R8 irq set", {31'd0, irq}, 32'h1);
    wr(6'h14, 32'h00);
    rd(6'h0C, d); check("R7 zero write no effect", d, 32'h04);
    wr(6'h14, 32'h04);
    rd(6'h0C, d); check("R7 clear", d, 32'h0);
    check("R8 irq drops", {31'd0, irq}, 32'h0);

    // R9: any-transition on pin 2, clear lands with the event
    wr(6'h24, 32'h04);
    settle();
    wr(6'h14, 32'hFF);
    @(negedge clk);
    pin_in = 8'h00;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h14; bus_wdata = 32'h04;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd(6'h0C, d); check("R9 event beats clear", d, 32'h04);
    check("R9 irq held", {31'd0, irq}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule